// File: doc/BRIEF.md
# Reference-Clock Frequency Lock Controller

This controller judges whether a recovered data clock runs at a rate tied to a reference clock, and reports how far it is from that rate. Software writes one control byte. Two mode bits choose between holding the recovered clock against the reference and measuring its rate. A 2-bit prescale code brings the reference down into its base band. A 4-bit exponent gives the expected power-of-two ratio between the data rate and the divided reference.

The measurement window is WIN cycles of the divided reference. A counter in the recovered-clock domain counts the recovered-clock cycles in each window. The window boundary and the captured count cross between the two clock domains through a two-flop synchronised toggle request and acknowledge. In lock mode each count is compared with WIN·2^n. From the results the block drives a lock flag and a speed-up or slow-down direction, and it re-acquires lock by itself after losing it. In measure mode the block shows the raw window count instead.

The control port and all outputs are in the reference-clock domain. The analog loop that acts on the direction outputs lies outside this block.

Top module: `reflock_ctrl`

## Requirements
- R1: After reset, and whenever ctrl[1:0] is 00 (idle), locked, freq_up, freq_dn, cfg_err and meas_count are all 0.
- R2: Writing ctrl[1:0]=11 is an error. cfg_err becomes 1, neither mode starts, and locked, freq_up, freq_dn and meas_count are held at 0.
- R3: ctrl[7:6]=r divides the reference by 2^r, and ctrl[5:2]=n sets the expected count to WIN·2^n recovered cycles per window of WIN divided-reference cycles.
- R4: In lock mode (ctrl[1:0]=01), the first two window results after a start are discarded. locked rises after 4 consecutive windows whose count error is at most tol_in = (expected>>11)+SLACK.
- R5: locked falls after 2 consecutive windows whose count error exceeds tol_out = (expected>>10)+2·SLACK.
- R6: freq_up is 1 when expected minus measured exceeds tol_in, and freq_dn is 1 when measured minus expected exceeds tol_in. Both follow the most recent window and are never both 1.
- R7: A write that keeps the block in lock mode with different ctrl[7:2] fields has no effect on the expected count or the lock state.
- R8: A write that moves the block into lock mode from any other mode (a 0-to-1 of ctrl[0], or leaving the error state) latches ctrl[7:2], clears the lock state and starts a new attempt.
- R9: After lock is lost, locked returns without any write once the recovered rate is back within tolerance.
- R10: In measure mode (ctrl[1:0]=10), locked, freq_up and freq_dn are 0, and meas_count shows the recovered-clock count of the latest window, with the first two results discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; domain of the control port and outputs |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| rec_clk | input | 1 | Recovered data clock being judged |
| rec_rst_n | input | 1 | Synchronous active-low reset, recovered domain |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte: [7:6] prescale code, [5:2] ratio exponent, [1:0] mode |
| locked | output | 1 | Recovered clock is held at the target rate |
| freq_up | output | 1 | Recovered clock is too slow |
| freq_dn | output | 1 | Recovered clock is too fast |
| cfg_err | output | 1 | Both mode bits are set |
| meas_count | output | $clog2(WIN)+10 | Latest window count in measure mode |

## Verification
The assertions assume that reset is held from time zero, and that a window lasts far longer than the round trip of the request and acknowledge toggles, so the captured count is stable whenever it is read. The bench keeps the recovered period between a quarter of the reference period and one reference period, and keeps the exponent no more than two above the prescale code. This keeps counts far from saturation and windows long against the synchroniser delay. Its off-rate excursions are ±10 %, well outside both tolerances even at the smallest expected count.

// File: rtl/reflock_pkg.sv
// Shared types for the reference-clock lock controller.
// Assumes: the mode encoding matches the two low control bits.
package reflock_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_LOCK = 2'b01,
        MODE_MEAS = 2'b10,
        MODE_ERR  = 2'b11
    } mode_e;

    typedef struct packed {
        logic [1:0] range;   // reference prescale exponent
        logic [3:0] ratio;   // data-to-reference ratio exponent
    } cfg_t;
endpackage

// File: rtl/reflock_regs.sv
// Control byte decode: holds the current mode and latches the prescale and
// ratio fields only when a mode is newly entered. That entry also produces a
// one-cycle restart pulse. Assumes wr_en and wr_data are in the ref_clk domain.
module reflock_regs
    import reflock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output mode_e      mode,
    output cfg_t       cfg,
    output logic       restart
);
    mode_e wr_mode;
    logic  enter;

    // Purpose: decode the mode being written and whether it is a fresh entry.
    always_comb begin
        wr_mode = mode_e'(wr_data[1:0]);
        enter   = wr_en && (wr_mode == MODE_LOCK || wr_mode == MODE_MEAS)
                  && (wr_mode != mode);
    end

    // Purpose: register the mode, latch the fields on entry, pulse restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_IDLE;
            cfg     <= '0;
            restart <= 1'b0;
        end else begin
            restart <= enter;
            if (wr_en) mode <= wr_mode;
            if (enter) cfg <= cfg_t'(wr_data[7:2]);
        end
    end

    // R2: the error mode never launches an attempt
    a_r2_err_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ERR) |-> !restart);
    // R7: latched fields change only together with a restart
    a_r7_cfg_only_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> restart);
endmodule

// File: rtl/reflock_window.sv
// Window timer and cross-domain counter. The reference side prescales by
// 2^range, counts WIN ticks and then toggles a request. The recovered side
// synchronises the request, captures its free-running cycle count and toggles
// an acknowledge. The reference side sees that as res_vld. Assumes WIN >= 2
// and a window much longer than the synchroniser round trip.
module reflock_window #(
    parameter int WIN = 1024,
    parameter int CW  = 20
) (
    input  logic          ref_clk,
    input  logic          ref_rst_n,
    input  logic          rec_clk,
    input  logic          rec_rst_n,
    input  logic          restart,
    input  logic          active,
    input  logic [1:0]    range,
    output logic          res_vld,
    output logic [CW-1:0] res_count
);
    localparam int WW = $clog2(WIN);

    logic [2:0]    pre_cnt;
    logic [2:0]    pre_lim;
    logic [WW-1:0] win_cnt;
    logic          req_tgl;
    logic          rq_s1, rq_s2, rq_s3;
    logic [CW-1:0] rec_cnt;
    logic [CW-1:0] cap_q;
    logic          ack_tgl;
    logic          ak_s1, ak_s2, ak_s3;

    // Purpose: last prescaler state before a divided-reference tick.
    always_comb pre_lim = 3'((4'd1 << range) - 4'd1);

    // Purpose: divide the reference and time WIN ticks, then toggle a request.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            pre_cnt <= '0;
            win_cnt <= '0;
            req_tgl <= 1'b0;
        end else if (restart || !active) begin
            pre_cnt <= '0;
            win_cnt <= '0;
        end else if (pre_cnt == pre_lim) begin
            pre_cnt <= '0;
            if (win_cnt == WW'(WIN - 1)) begin
                win_cnt <= '0;
                req_tgl <= ~req_tgl;
            end else begin
                win_cnt <= win_cnt + 1'b1;
            end
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // Purpose: synchronise the request, capture the count and acknowledge.
    always_ff @(posedge rec_clk) begin
        if (!rec_rst_n) begin
            rq_s1   <= 1'b0;
            rq_s2   <= 1'b0;
            rq_s3   <= 1'b0;
            rec_cnt <= '0;
            cap_q   <= '0;
            ack_tgl <= 1'b0;
        end else begin
            rq_s1 <= req_tgl;
            rq_s2 <= rq_s1;
            rq_s3 <= rq_s2;
            if (rq_s2 != rq_s3) begin
                cap_q   <= rec_cnt;
                rec_cnt <= CW'(1);
                ack_tgl <= rq_s2;
            end else if (rec_cnt != '1) begin
                rec_cnt <= rec_cnt + 1'b1;
            end
        end
    end

    // Purpose: bring the acknowledge back into the reference domain.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            ak_s1 <= 1'b0;
            ak_s2 <= 1'b0;
            ak_s3 <= 1'b0;
        end else begin
            ak_s1 <= ack_tgl;
            ak_s2 <= ak_s1;
            ak_s3 <= ak_s2;
        end
    end

    assign res_vld   = ak_s2 ^ ak_s3;
    assign res_count = cap_q;

    // R3: the prescaler never passes its limit
    a_r3_prescale_bound: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        pre_cnt <= pre_lim || restart || !active);
endmodule

// File: rtl/reflock_judge.sv
// Window judge. It compares each result with WIN*2^ratio and runs the
// consecutive-window lock and loss counters. It drives the direction outputs
// with a deadband of tol_in, and it holds the measure-mode count. Assumes
// res_count is stable while res_vld is high.
module reflock_judge
    import reflock_pkg::*;
#(
    parameter int WIN         = 1024,
    parameter int CW          = 20,
    parameter int SLACK       = 2,
    parameter int TIGHT_SHIFT = 11,
    parameter int LOOSE_SHIFT = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  cfg_t          cfg,
    input  logic          restart,
    input  logic          res_vld,
    input  logic [CW-1:0] res_count,
    output logic          locked,
    output logic          freq_up,
    output logic          freq_dn,
    output logic [CW-1:0] meas_count
);
    logic [CW-1:0] exp_cnt, tol_in, tol_out, mag;
    logic          slow;
    logic [1:0]    skip;
    logic [2:0]    good;
    logic          bad;

    // Purpose: expected count, tolerance bands and error magnitude and sign.
    always_comb begin
        exp_cnt = CW'(WIN) << cfg.ratio;
        tol_in  = (exp_cnt >> TIGHT_SHIFT) + CW'(SLACK);
        tol_out = (exp_cnt >> LOOSE_SHIFT) + CW'(2 * SLACK);
        slow    = exp_cnt >= res_count;
        mag     = slow ? exp_cnt - res_count : res_count - exp_cnt;
    end

    // Purpose: per-window lock, loss, direction and measure bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || mode == MODE_IDLE || mode == MODE_ERR) begin
            locked     <= 1'b0;
            freq_up    <= 1'b0;
            freq_dn    <= 1'b0;
            good       <= '0;
            bad        <= 1'b0;
            skip       <= 2'd2;
            meas_count <= '0;
        end else if (mode == MODE_MEAS) begin
            locked  <= 1'b0;
            freq_up <= 1'b0;
            freq_dn <= 1'b0;
            if (res_vld) begin
                if (skip != 2'd0) skip <= skip - 1'b1;
                else              meas_count <= res_count;
            end
        end else begin
            meas_count <= '0;
            if (res_vld) begin
                if (skip != 2'd0) begin
                    skip <= skip - 1'b1;
                end else begin
                    freq_up <= slow && (mag > tol_in);
                    freq_dn <= !slow && (mag > tol_in);
                    if (mag <= tol_in) begin
                        bad <= 1'b0;
                        if (good != 3'd4) good <= good + 1'b1;
                        if (good == 3'd3) locked <= 1'b1;
                    end else if (mag > tol_out) begin
                        good <= '0;
                        bad  <= !bad;
                        if (bad) locked <= 1'b0;
                    end else begin
                        good <= '0;
                        bad  <= 1'b0;
                    end
                end
            end
        end
    end

    // R6: never both directions
    a_r6_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(freq_up && freq_dn));
    // R1: quiet outputs outside lock mode
    a_r1_quiet_outside_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_LOCK) |=> (!locked && !freq_up && !freq_dn));
    // R4: lock is granted only on a window result
    a_r4_lock_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(res_vld));
    // R5: lock drops only on a result, a mode change or a restart
    a_r5_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> ($past(res_vld) || $past(mode != MODE_LOCK) || $past(restart)));
endmodule

// File: rtl/reflock_ctrl.sv
// Top of the reference-clock lock controller. It joins the control decode,
// the cross-domain window counter and the judge. Assumes both resets are held
// at start-up and that the control port is written in the ref_clk domain.
module reflock_ctrl
    import reflock_pkg::*;
#(
    parameter int WIN   = 1024,
    parameter int SLACK = 2
) (
    input  logic                      ref_clk,
    input  logic                      ref_rst_n,
    input  logic                      rec_clk,
    input  logic                      rec_rst_n,
    input  logic                      wr_en,
    input  logic [7:0]                wr_data,
    output logic                      locked,
    output logic                      freq_up,
    output logic                      freq_dn,
    output logic                      cfg_err,
    output logic [$clog2(WIN)+9:0]    meas_count
);
    localparam int CW = $clog2(WIN) + 10;

    mode_e         mode;
    cfg_t          cfg;
    logic          restart;
    logic          active;
    logic          res_vld;
    logic [CW-1:0] res_count;

    assign active  = (mode == MODE_LOCK) || (mode == MODE_MEAS);
    assign cfg_err = (mode == MODE_ERR);

    reflock_regs u_regs (
        .clk     (ref_clk),
        .rst_n   (ref_rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mode    (mode),
        .cfg     (cfg),
        .restart (restart)
    );

    reflock_window #(.WIN(WIN), .CW(CW)) u_window (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .rec_clk   (rec_clk),
        .rec_rst_n (rec_rst_n),
        .restart   (restart),
        .active    (active),
        .range     (cfg.range),
        .res_vld   (res_vld),
        .res_count (res_count)
    );

    reflock_judge #(.WIN(WIN), .CW(CW), .SLACK(SLACK)) u_judge (
        .clk        (ref_clk),
        .rst_n      (ref_rst_n),
        .mode       (mode),
        .cfg        (cfg),
        .restart    (restart),
        .res_vld    (res_vld),
        .res_count  (res_count),
        .locked     (locked),
        .freq_up    (freq_up),
        .freq_dn    (freq_dn),
        .meas_count (meas_count)
    );
endmodule

// File: tb/reflock_ctrl_bench.sv
`timescale 1ns/1ps
module reflock_ctrl_bench;
    localparam int WIN = 64;
    localparam int CW  = $clog2(WIN) + 10;

    logic          ref_clk = 1'b0;
    logic          rec_clk = 1'b0;
    logic          ref_rst_n = 1'b0;
    logic          rec_rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          locked, freq_up, freq_dn, cfg_err;
    logic [CW-1:0] meas_count;
    real           rec_half = 2.0;
    int            total = 0;
    int            bad = 0;

    reflock_ctrl #(.WIN(WIN)) u_reflock_ctrl (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .rec_clk(rec_clk), .rec_rst_n(rec_rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .locked(locked), .freq_up(freq_up),
        .freq_dn(freq_dn), .cfg_err(cfg_err), .meas_count(meas_count)
    );

    always #2 ref_clk = ~ref_clk;
    always #(rec_half) rec_clk = ~rec_clk;

    function automatic int exp_count(input int n);
        return WIN << n;
    endfunction

    function automatic logic [7:0] ctrl_byte(input int rng, input int n, input logic [1:0] md);
        return {rng[1:0], n[3:0], md};
    endfunction

    // recovered half period for a target ratio, scaled (>1 means slower)
    task automatic set_rate(input int rng, input int n, input real scale);
        rec_half = 2.0 * (2.0 ** rng) / (2.0 ** n) * scale;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge ref_clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge ref_clk);
        wr_en = 1'b0;
        repeat (4) @(negedge ref_clk);
    endtask

    task automatic wait_win(input int rng, input int k);
        repeat (k * (WIN << rng) + 40) @(negedge ref_clk);
    endtask

    task automatic lock_cycle(input int rng, input int n, input bit full);
        set_rate(rng, n, 1.0);
        wr(8'h00);
        wr(ctrl_byte(rng, n, 2'b01));
        wait_win(rng, 8);
        chk(locked == 1'b1, "R4 lock at nominal rate (R3 ratio)", int'(locked), 1);
        chk(!freq_up && !freq_dn, "R6 no direction at nominal", int'({freq_up, freq_dn}), 0);
        if (full) begin
            set_rate(rng, n, 1.10);
            wait_win(rng, 4);
            chk(locked == 1'b0, "R5 lock lost when slow", int'(locked), 0);
            chk(freq_up && !freq_dn, "R6 up when slow", int'({freq_up, freq_dn}), 2);
            set_rate(rng, n, 1.0);
            wait_win(rng, 7);
            chk(locked == 1'b1, "R9 re-acquire without write", int'(locked), 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge ref_clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (6) @(negedge ref_clk);
        ref_rst_n = 1'b1;
        rec_rst_n = 1'b1;
        repeat (3) @(negedge ref_clk);

        // R1 reset state
        chk(!locked && !freq_up && !freq_dn && !cfg_err && meas_count == 0,
            "R1 reset outputs", int'({locked, freq_up, freq_dn, cfg_err}), 0);

        // directed corners then random configurations (R3 with every prescale code)
        lock_cycle(0, 0, 1'b1);
        lock_cycle(3, 5, 1'b1);
        for (int i = 0; i < 4; i++) begin
            int rng;
            int n;
            rng = int'($urandom % 4);
            n   = rng + int'($urandom % 3);
            lock_cycle(rng, n, 1'b1);
        end

        // R6 fast recovered clock gives down
        lock_cycle(1, 2, 1'b0);
        set_rate(1, 2, 0.90);
        wait_win(1, 4);
        chk(!freq_up && freq_dn, "R6 down when fast", int'({freq_up, freq_dn}), 1);
        chk(locked == 1'b0, "R5 lock lost when fast", int'(locked), 0);

        // R7 field rewrite while locked is ignored
        lock_cycle(2, 3, 1'b0);
        wr(ctrl_byte(2, 4, 2'b01));
        wait_win(2, 6);
        chk(locked == 1'b1, "R7 fields ignored while locked", int'(locked), 1);
        chk(!freq_up && !freq_dn, "R7 no direction after ignored write", int'({freq_up, freq_dn}), 0);

        // R8 fresh 0-to-1 applies the new ratio (now twice the actual rate)
        wr(8'h00);
        wr(ctrl_byte(2, 4, 2'b01));
        wait_win(2, 8);
        chk(locked == 1'b0, "R8 new ratio applied on restart", int'(locked), 0);
        chk(freq_up && !freq_dn, "R8 up after new ratio", int'({freq_up, freq_dn}), 2);

        // R2 both mode bits set
        wr(ctrl_byte(2, 3, 2'b11));
        chk(cfg_err == 1'b1, "R2 error flag", int'(cfg_err), 1);
        chk(!locked && !freq_up && !freq_dn && meas_count == 0, "R2 outputs held",
            int'({locked, freq_up, freq_dn}), 0);
        wait_win(2, 3);
        chk(!locked && meas_count == 0, "R2 no mode entered", int'(locked), 0);

        // R8 leaving error into lock mode starts an attempt
        wr(ctrl_byte(2, 3, 2'b01));
        chk(cfg_err == 1'b0, "R8 error cleared", int'(cfg_err), 0);
        wait_win(2, 8);
        chk(locked == 1'b1, "R8 lock after leaving error", int'(locked), 1);

        // R10 measure mode, nominal then slow
        set_rate(1, 3, 1.0);
        wr(ctrl_byte(1, 3, 2'b10));
        wait_win(1, 5);
        chk(int'(meas_count) >= exp_count(3) - 2 && int'(meas_count) <= exp_count(3) + 2,
            "R10 measured count", int'(meas_count), exp_count(3));
        chk(!locked && !freq_up && !freq_dn, "R10 lock outputs quiet",
            int'({locked, freq_up, freq_dn}), 0);
        set_rate(1, 3, 1.10);
        wait_win(1, 3);
        begin
            int e;
            e = int'(real'(exp_count(3)) / 1.10);
            chk(int'(meas_count) >= e - 3 && int'(meas_count) <= e + 3,
                "R10 measured slow count", int'(meas_count), e);
        end

        // R1 idle clears everything
        wr(8'h00);
        chk(!locked && !freq_up && !freq_dn && !cfg_err && meas_count == 0,
            "R1 idle outputs", int'(meas_count), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule